// File: doc/BRIEF.md
# Special-Register and RAM Data Memory with Pointer Windows

This block is the 256-byte data space of a small 8-bit controller core. One address bus reaches both the special-function registers in the low part of the map and the general-purpose RAM above them. Two locations have no storage of their own. They act as windows: an access to one of them is redirected to the address held in a matching pointer register. Any unassigned location in the low region reads as zero, and writes to it are dropped.

Each cycle the core presents one direct address. It can assert a read strobe, a byte-write strobe, or a single-bit set/clear request. Reads are combinational from the resolved address. Writes and bit operations land on the rising clock edge. A bit operation is a read-modify-write of the resolved location and finishes in one cycle. The accumulator and status register are also driven out continuously for the datapath. The storage behind the interrupt, timer and port addresses is plain register storage here.

The status register has flag positions C=bit0, AC=bit1, Z=bit2, OV=bit3, PD=bit4 and TO=bit5. Bits 6 and 7 are plain storage. PD and TO are protected against every data write.

Top module: `dmem_regfile`

## Requirements
- R1: Locations 01h (pointer 0), 03h (pointer 1), 05h (accumulator), 0Ah (status), 0Bh (interrupt control), 0Dh (timer count) and 0Eh (timer control) hold written bytes and read them back. `acc_q` always shows 05h and `stat_q` always shows 0Ah.
- R2: Five port data registers at 12h, 14h, 16h, 18h and 1Ah, and their direction registers at 13h, 15h, 17h, 19h and 1Bh, hold written bytes and read them back.
- R3: Every other address below 60h reads 00h, and byte writes or bit operations to it change nothing.
- R4: Addresses 60h through FFh are general-purpose RAM bytes that hold written data.
- R5: A read, write or bit operation at 00h acts on the address held in pointer 0 (01h). One at 02h acts on the address held in pointer 1 (03h). A pointer may hold any value 00h–FFh.
- R6: When the pointer used by an access holds 00h or 02h, a read through it returns 00h, and a write or bit operation through it changes nothing.
- R7: With `bit_op_en` high and `wr_en` low, bit `bit_sel` of the resolved location becomes `bit_val` and every other bit is kept, all in one clock edge.
- R8: Status bits 4 (PD) and 5 (TO) are left unchanged by byte writes and bit operations. The other six status bits are writable.
- R9: `rd_data` is 00h whenever `rd_en` is low.
- R10: While `rst_n` is low, every register, pointer and RAM byte clears to 00h.
- R11: When `wr_en` and `bit_op_en` are both high, the byte write is performed and the bit operation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| addr | input | 8 | Direct address of the access |
| rd_en | input | 1 | Read strobe; gates `rd_data` |
| wr_en | input | 1 | Byte-write strobe |
| wr_data | input | 8 | Byte to write |
| bit_op_en | input | 1 | Single-bit set/clear request |
| bit_sel | input | 3 | Bit index for the bit operation |
| bit_val | input | 1 | Value given to the selected bit |
| rd_data | output | 8 | Combinational read data of the resolved location |
| acc_q | output | 8 | Current accumulator value |
| stat_q | output | 8 | Current status register value |

## Verification
The properties assume that inputs are settled around each rising edge and that `bit_sel` is never unknown while `bit_op_en` is high. The bench meets this by driving every input on the falling edge and returning the strobes to zero after each operation. Pointer values written by the random stimulus are drawn mostly from the window addresses, the RAM edges and the reserved holes. This makes the window-on-window cases and the boundary crossings come up often, while every address is still reachable.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int DW = 8;
  typedef logic [DW-1:0] byte_t;

  // window locations and their pointers
  localparam byte_t WIN0_A  = 8'h00;
  localparam byte_t PTR0_A  = 8'h01;
  localparam byte_t WIN1_A  = 8'h02;
  localparam byte_t PTR1_A  = 8'h03;
  // core registers
  localparam byte_t ACC_A   = 8'h05;
  localparam byte_t STAT_A  = 8'h0A;
  localparam byte_t IRQC_A  = 8'h0B;
  localparam byte_t TCNT_A  = 8'h0D;
  localparam byte_t TCTL_A  = 8'h0E;
  // port pairs: data at base+2i, direction at base+2i+1
  localparam byte_t PORT_BASE_A = 8'h12;
  localparam int    NUM_PORTS   = 5;
  // general-purpose RAM start
  localparam byte_t RAM_BASE_A  = 8'h60;
  // status bits that data writes may not alter (PD=4, TO=5)
  localparam byte_t STAT_PROT   = 8'h30;
endpackage

// File: rtl/dmem_addr_resolve.sv
module dmem_addr_resolve
  import dmem_pkg::*;
(
  input  byte_t addr,
  input  byte_t ptr0,
  input  byte_t ptr1,
  output byte_t phys,
  output logic  null_acc
);
  logic via_ptr;

  always_comb begin
    via_ptr = 1'b0;
    phys    = addr;
    if (addr == WIN0_A) begin
      via_ptr = 1'b1;
      phys    = ptr0;
    end else if (addr == WIN1_A) begin
      via_ptr = 1'b1;
      phys    = ptr1;
    end
    null_acc = via_ptr && ((phys == WIN0_A) || (phys == WIN1_A));
  end
endmodule

// File: rtl/dmem_sfr_bank.sv
module dmem_sfr_bank
  import dmem_pkg::*;
#(
  parameter int    PORTS    = NUM_PORTS,
  parameter byte_t PBASE    = PORT_BASE_A,
  parameter byte_t PROT_MSK = STAT_PROT
) (
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t sel,
  input  logic  we,
  input  byte_t wdata,
  output byte_t rd_val,
  output logic  hit,
  output byte_t acc_q,
  output byte_t stat_q,
  output byte_t ptr0_q,
  output byte_t ptr1_q
);
  byte_t ptr0_r, ptr1_r, acc_r, stat_r, irqc_r, tcnt_r, tctl_r;
  byte_t stat_nx;
  logic  en_ptr0, en_ptr1, en_acc, en_stat, en_irqc, en_tcnt, en_tctl;
  logic [PORTS-1:0][DW-1:0] pdat_v, pdir_v;
  logic [PORTS-1:0]         pdat_sel, pdir_sel;

  // next-state / enables
  always_comb begin
    en_ptr0 = we && (sel == PTR0_A);
    en_ptr1 = we && (sel == PTR1_A);
    en_acc  = we && (sel == ACC_A);
    en_stat = we && (sel == STAT_A);
    en_irqc = we && (sel == IRQC_A);
    en_tcnt = we && (sel == TCNT_A);
    en_tctl = we && (sel == TCTL_A);
    stat_nx = (wdata & ~PROT_MSK) | (stat_r & PROT_MSK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr0_r <= '0;
      ptr1_r <= '0;
      acc_r  <= '0;
      stat_r <= '0;
      irqc_r <= '0;
      tcnt_r <= '0;
      tctl_r <= '0;
    end else begin
      if (en_ptr0) ptr0_r <= wdata;
      if (en_ptr1) ptr1_r <= wdata;
      if (en_acc)  acc_r  <= wdata;
      if (en_stat) stat_r <= stat_nx;
      if (en_irqc) irqc_r <= wdata;
      if (en_tcnt) tcnt_r <= wdata;
      if (en_tctl) tctl_r <= wdata;
    end
  end

  for (genvar g = 0; g < PORTS; g++) begin : g_port
    localparam byte_t DAT_A = byte_t'(PBASE + byte_t'(2 * g));
    localparam byte_t DIR_A = byte_t'(PBASE + byte_t'(2 * g + 1));
    byte_t dat_r, dir_r;
    logic  en_dat, en_dir;

    always_comb begin
      en_dat = we && (sel == DAT_A);
      en_dir = we && (sel == DIR_A);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_r <= '0;
        dir_r <= '0;
      end else begin
        if (en_dat) dat_r <= wdata;
        if (en_dir) dir_r <= wdata;
      end
    end

    assign pdat_v[g]   = dat_r;
    assign pdir_v[g]   = dir_r;
    assign pdat_sel[g] = (sel == DAT_A);
    assign pdir_sel[g] = (sel == DIR_A);
  end

  // read mux
  always_comb begin
    hit    = 1'b1;
    rd_val = '0;
    unique case (sel)
      PTR0_A:  rd_val = ptr0_r;
      PTR1_A:  rd_val = ptr1_r;
      ACC_A:   rd_val = acc_r;
      STAT_A:  rd_val = stat_r;
      IRQC_A:  rd_val = irqc_r;
      TCNT_A:  rd_val = tcnt_r;
      TCTL_A:  rd_val = tctl_r;
      default: hit = 1'b0;
    endcase
    for (int i = 0; i < PORTS; i++) begin
      if (pdat_sel[i]) begin
        hit    = 1'b1;
        rd_val = pdat_v[i];
      end
      if (pdir_sel[i]) begin
        hit    = 1'b1;
        rd_val = pdir_v[i];
      end
    end
  end

  assign acc_q  = acc_r;
  assign stat_q = stat_r;
  assign ptr0_q = ptr0_r;
  assign ptr1_q = ptr1_r;
endmodule

// File: rtl/dmem_gpr_ram.sv
module dmem_gpr_ram
  import dmem_pkg::*;
#(
  parameter byte_t BASE  = RAM_BASE_A,
  parameter int    DEPTH = 256 - int'(BASE)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t sel,
  input  logic  we,
  input  byte_t wdata,
  output byte_t rd_val,
  output logic  hit
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  byte_t          mem [DEPTH];
  logic  [IW-1:0] idx;
  logic           en_wr;

  always_comb begin
    hit   = (sel >= BASE);
    idx   = IW'(sel - BASE);
    en_wr = we && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (en_wr) begin
      mem[idx] <= wdata;
    end
  end

  assign rd_val = hit ? mem[idx] : '0;
endmodule

// File: rtl/dmem_regfile.sv
module dmem_regfile
  import dmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       bit_op_en,
  input  logic [2:0] bit_sel,
  input  logic       bit_val,
  output logic [7:0] rd_data,
  output logic [7:0] acc_q,
  output logic [7:0] stat_q
);
  byte_t phys, ptr0_q, ptr1_q;
  byte_t sfr_rd, ram_rd, loc_val, bit_mod, wsel;
  logic  null_acc, sfr_hit, ram_hit, store_en;

  dmem_addr_resolve u_res (
    .addr     (addr),
    .ptr0     (ptr0_q),
    .ptr1     (ptr1_q),
    .phys     (phys),
    .null_acc (null_acc)
  );

  // location value and write data selection
  always_comb begin
    if (null_acc)     loc_val = '0;
    else if (sfr_hit) loc_val = sfr_rd;
    else if (ram_hit) loc_val = ram_rd;
    else              loc_val = '0;
    bit_mod          = loc_val;
    bit_mod[bit_sel] = bit_val;
    wsel             = wr_en ? wr_data : bit_mod;
    store_en         = (wr_en || bit_op_en) && !null_acc;
  end

  dmem_sfr_bank u_sfr (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (phys),
    .we     (store_en),
    .wdata  (wsel),
    .rd_val (sfr_rd),
    .hit    (sfr_hit),
    .acc_q  (acc_q),
    .stat_q (stat_q),
    .ptr0_q (ptr0_q),
    .ptr1_q (ptr1_q)
  );

  dmem_gpr_ram u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (phys),
    .we     (store_en),
    .wdata  (wsel),
    .rd_val (ram_rd),
    .hit    (ram_hit)
  );

  assign rd_data = rd_en ? loc_val : '0;
endmodule

// File: rtl/dmem_regfile_chk.sv
module dmem_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       bit_op_en,
  input logic [2:0] bit_sel,
  input logic       bit_val,
  input logic [7:0] rd_data,
  input logic [7:0] acc_q,
  input logic [7:0] stat_q,
  input logic [7:0] ptr0,
  input logic [7:0] ptr1
);
  // R1
  acc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h05) |=> (acc_q == $past(wr_data)));

  // R7
  acc_bitop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_op_en && !wr_en && addr == 8'h05) |=> (acc_q[$past(bit_sel)] == $past(bit_val)));

  // R8
  stat_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(stat_q[5:4]));

  // R8
  stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h0A) |=> (stat_q[3:0] == $past(wr_data[3:0]) &&
                                  stat_q[7:6] == $past(wr_data[7:6])));

  // R9
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == 8'h00));

  // R6
  win0_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'h00 && (ptr0 == 8'h00 || ptr0 == 8'h02)) |-> (rd_data == 8'h00));

  // R6
  win1_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'h02 && (ptr1 == 8'h00 || ptr1 == 8'h02)) |-> (rd_data == 8'h00));

  // R3
  hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 8'h04 || addr == 8'h1C || addr == 8'h5F)) |-> (rd_data == 8'h00));
endmodule

bind dmem_regfile dmem_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .bit_op_en (bit_op_en),
  .bit_sel   (bit_sel),
  .bit_val   (bit_val),
  .rd_data   (rd_data),
  .acc_q     (acc_q),
  .stat_q    (stat_q),
  .ptr0      (ptr0_q),
  .ptr1      (ptr1_q)
);

// File: tb/dmem_regfile_bench.sv
`timescale 1ns/1ps
module dmem_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr;
  logic       rd_en, wr_en, bit_op_en, bit_val;
  logic [7:0] wr_data;
  logic [2:0] bit_sel;
  logic [7:0] rd_data, acc_q, stat_q;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] ref_mem [256];

  always #2 clk = ~clk;

  dmem_regfile u_dmem_regfile (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .bit_op_en(bit_op_en), .bit_sel(bit_sel),
    .bit_val(bit_val), .rd_data(rd_data), .acc_q(acc_q), .stat_q(stat_q)
  );

  function automatic bit is_phys(logic [7:0] t);
    if (t == 8'h01 || t == 8'h03 || t == 8'h05 || t == 8'h0A || t == 8'h0B ||
        t == 8'h0D || t == 8'h0E) return 1'b1;
    if (t >= 8'h12 && t <= 8'h1B) return 1'b1;
    return (t >= 8'h60);
  endfunction

  function automatic logic [7:0] target(logic [7:0] a);
    if (a == 8'h00) return ref_mem[1];
    if (a == 8'h02) return ref_mem[3];
    return a;
  endfunction

  function automatic bit is_null(logic [7:0] a);
    logic [7:0] t = target(a);
    return (a == 8'h00 || a == 8'h02) && (t == 8'h00 || t == 8'h02);
  endfunction

  function automatic logic [7:0] m_rd(logic [7:0] a);
    logic [7:0] t = target(a);
    if (is_null(a) || !is_phys(t)) return 8'h00;
    return ref_mem[t];
  endfunction

  function automatic void m_store(logic [7:0] a, logic [7:0] d);
    logic [7:0] t = target(a);
    if (is_null(a) || !is_phys(t)) return;
    if (t == 8'h0A) ref_mem[t] = (d & 8'hCF) | (ref_mem[t] & 8'h30);
    else            ref_mem[t] = d;
  endfunction

  function automatic string req_of(logic [7:0] a);
    logic [7:0] t = target(a);
    if (a == 8'h00 || a == 8'h02) return is_null(a) ? "R6" : "R5";
    if (t >= 8'h60) return "R4";
    if (t >= 8'h12 && t <= 8'h1B) return "R2";
    if (is_phys(t)) return "R1";
    return "R3";
  endfunction

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", r, act, exp);
    end
  endtask

  // one clocked operation; the model is updated after the edge
  task automatic op(logic [7:0] a, logic [7:0] d, bit we, bit be, logic [2:0] bs, bit bv);
    logic [7:0] nv;
    @(negedge clk);
    addr = a; wr_data = d; wr_en = we; bit_op_en = be; bit_sel = bs; bit_val = bv;
    @(posedge clk);
    #1;
    wr_en = 1'b0; bit_op_en = 1'b0;
    if (we) m_store(a, d);
    else if (be) begin
      nv = m_rd(a);
      nv[bs] = bv;
      m_store(a, nv);
    end
  endtask

  task automatic rd_chk(logic [7:0] a, string r = "");
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    chk((r == "") ? req_of(a) : r, rd_data, m_rd(a));
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] pick_addr();
    logic [7:0] pool [16] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h0A, 8'h0B, 8'h0D,
                              8'h0E, 8'h04, 8'h1C, 8'h5F, 8'h60, 8'hFF, 8'h12, 8'h1B};
    if ($urandom_range(0, 1) == 0) return pool[$urandom_range(0, 15)];
    return 8'($urandom);
  endfunction

  function automatic logic [7:0] pick_ptr();
    logic [7:0] pool [8] = '{8'h00, 8'h02, 8'h05, 8'h0A, 8'h5F, 8'h60, 8'hFF, 8'h04};
    if ($urandom_range(0, 2) != 0) return pool[$urandom_range(0, 7)];
    return 8'($urandom);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4417));
    foreach (ref_mem[i]) ref_mem[i] = 8'h00;
    addr = '0; rd_en = 0; wr_en = 0; wr_data = '0; bit_op_en = 0; bit_sel = '0; bit_val = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10: everything zero after reset
    for (int a = 0; a < 256; a++) rd_chk(8'(a), "R10");
    chk("R10", acc_q, 8'h00);
    chk("R10", stat_q, 8'h00);

    // R8: protected status bits
    op(8'h0A, 8'hFF, 1, 0, 0, 0);
    chk("R8", stat_q, 8'hCF);
    op(8'h0A, 8'h00, 0, 1, 3'd5, 1);
    chk("R8", stat_q, 8'hCF);
    op(8'h0A, 8'h00, 0, 1, 3'd4, 1);
    chk("R8", stat_q, 8'hCF);
    op(8'h0A, 8'h00, 0, 1, 3'd0, 0);
    chk("R8", stat_q, 8'hCE);

    // R1 / R7: accumulator bit ops
    op(8'h05, 8'h5A, 1, 0, 0, 0);
    chk("R1", acc_q, 8'h5A);
    op(8'h05, 8'h00, 0, 1, 3'd7, 1);
    chk("R7", acc_q, 8'hDA);
    op(8'h05, 8'h00, 0, 1, 3'd1, 0);
    chk("R7", acc_q, 8'hD8);

    // R11: byte write wins over bit op
    op(8'h05, 8'h33, 1, 1, 3'd7, 1);
    chk("R11", acc_q, 8'h33);

    // R9: no read strobe gives zero
    @(negedge clk); addr = 8'h05; rd_en = 1'b0; #1;
    chk("R9", rd_data, 8'h00);

    // R3 / R4: RAM boundaries
    op(8'h5F, 8'hA5, 1, 0, 0, 0);
    rd_chk(8'h5F, "R3");
    op(8'h5F, 8'h00, 0, 1, 3'd2, 1);
    rd_chk(8'h5F, "R3");
    op(8'h60, 8'h61, 1, 0, 0, 0);
    rd_chk(8'h60, "R4");
    op(8'hFF, 8'hEE, 1, 0, 0, 0);
    rd_chk(8'hFF, "R4");

    // R5 / R7: through the windows
    op(8'h01, 8'h60, 1, 0, 0, 0);
    rd_chk(8'h00, "R5");
    op(8'h00, 8'h00, 0, 1, 3'd3, 1);
    rd_chk(8'h60, "R7");
    op(8'h03, 8'h05, 1, 0, 0, 0);
    op(8'h02, 8'h77, 1, 0, 0, 0);
    chk("R5", acc_q, 8'h77);

    // R6: pointers aimed at the windows
    op(8'h01, 8'h02, 1, 0, 0, 0);
    op(8'h03, 8'h00, 1, 0, 0, 0);
    rd_chk(8'h00, "R6");
    rd_chk(8'h02, "R6");
    op(8'h00, 8'h99, 1, 0, 0, 0);
    op(8'h02, 8'h00, 0, 1, 3'd0, 1);
    rd_chk(8'h01, "R6");
    rd_chk(8'h03, "R6");
    op(8'h03, 8'h02, 1, 0, 0, 0);
    op(8'h02, 8'h44, 1, 0, 0, 0);
    rd_chk(8'h03, "R6");

    // R2: each port pair
    for (int p = 0; p < 10; p++) begin
      op(8'(8'h12 + p), 8'(8'h80 + p), 1, 0, 0, 0);
      rd_chk(8'(8'h12 + p), "R2");
    end

    // random mix
    for (int it = 0; it < 4000; it++) begin
      logic [7:0] a, d;
      int k;
      a = pick_addr();
      d = (a == 8'h01 || a == 8'h03) ? pick_ptr() : 8'($urandom);
      k = $urandom_range(0, 9);
      if (k < 4)      op(a, d, 1, 0, 0, 0);
      else if (k < 7) op(a, d, 0, 1, 3'($urandom), 1'($urandom));
      else if (k < 9) op(a, d, 1, 1, 3'($urandom), 1'($urandom));
      rd_chk(pick_addr());
      chk("R1", acc_q, ref_mem[5]);
      chk("R8", stat_q, ref_mem[10]);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule